// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block controls an array of one-time programmable fuses organised as 8 banks of 256 byte-wide words. The array is modelled as sticky storage that is all zero after reset. A host reaches the block through a simple register bus. Through it the host sets a fuse address, starts an explicit sense cycle or a single-bit program cycle, polls busy and completion status, and reads and clears typed error flags. Each word also has a shadow copy that the host can read directly and can override by writing it. Three input vectors hold per-bank protection for programming, reading and overriding.

Bus addresses with bit 11 set reach the shadow copies: bits 10:8 select the bank and bits 7:0 select the row. Addresses with bit 11 clear and bits 10:4 zero reach the registers, decoded on bits 3:0:

| Offset | Register |
|--------|----------|
| 0 | status |
| 1 | status mask |
| 2 | error |
| 3 | error mask |
| 4 | function control |
| 5 | upper address |
| 6 | lower address |
| 7 | sense data |
| 8 | program key |

A program cycle and a sense cycle each keep the block busy for a parameterised number of clock cycles. When a cycle finishes, its own done flag is set in the status register. An interrupt output combines the flags that are set with their mask bits.

Top module: `efuse_ctrl`

## Requirements
- R1: After reset, the status, error and sense data registers read 0, every shadow word reads 0 and irq is low.
- R2: The upper address register holds the bank in bits 5:3 and row bits 7:5 in bits 2:0. The lower address register holds row bits 4:0 in bits 7:3 and the bit index in bits 2:0.
- R3: Writing 1 to bit 0 of function control while the key register holds 0xAA sets only the addressed fuse bit. Bits already set stay set. With any other key, error bit 7 is set, busy stays low and the array is unchanged.
- R4: A program request for a bank whose prot_prog bit is set, made with the correct key, sets error bit 6 and leaves the array unchanged.
- R5: Status bit 7 (busy) reads 1 for exactly PROG_CYCLES cycles after an accepted program start and for exactly SENSE_CYCLES cycles after an accepted sense start. A start written while busy is ignored.
- R6: When a program cycle ends, status bit 1 is set. When a sense cycle ends, status bit 0 is set and the sense data register holds the addressed fuse word. Function control bit 3 starts a sense cycle, and bit 0 takes priority when both are written.
- R7: A sense request for a bank whose prot_read bit is set sets error bit 2 and does not start a cycle.
- R8: A write to a shadow word makes later reads of that word return the written value. If the bank's prot_ovr bit is set, the write is refused, error bit 5 is set and the word keeps its value.
- R9: A shadow read (bus_rd) from a bank whose prot_read bit is set returns 0 and sets error bit 4.
- R10: A completed sense cycle reloads the shadow word from the fuses, so a previous override of that word no longer shows.
- R11: Writing 1 to a status done bit or an error bit clears it. Writing 0 leaves it unchanged.
- R12: irq is high exactly when some status done bit is set together with its bit in the status mask register, or some error bit is set together with its bit in the error mask register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (used for read-protect flagging) |
| bus_addr | input | 12 | Register or shadow address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| prot_prog | input | 8 | Per-bank program protection |
| prot_read | input | 8 | Per-bank read and sense protection |
| prot_ovr | input | 8 | Per-bank override protection |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach from the ports is a shadow word whose override hides fuse bits that were programmed later and then get exposed again by a sense reload. This needs an override, a program of the same word and a sense of it, in that order. The bench builds this directly on one word. It also mixes overrides, programs and senses over random addresses from a fixed seed, and checks every shadow read against a bench model that holds the fuse bits and the override flags separately. A start written in the middle of a busy window is driven deliberately to show that it is ignored.

// File: rtl/efuse_pkg.sv
package efuse_pkg;
  localparam int BANKS   = 8;
  localparam int ROWS    = 256;
  localparam int WBITS   = 8;
  localparam int BANK_W  = $clog2(BANKS);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int BIT_W   = $clog2(WBITS);
  localparam int IDX_W   = BANK_W + ROW_W;
  localparam int WORDS   = BANKS * ROWS;
  localparam int BUS_AW  = IDX_W + 1;
  localparam logic [7:0] UNLOCK_KEY = 8'hAA;

  localparam int E_PROG  = 7;
  localparam int E_WPROT = 6;
  localparam int E_OPROT = 5;
  localparam int E_RPROT = 4;
  localparam int E_SENSE = 2;
  localparam logic [7:0] ERR_VALID = 8'hFE;

  typedef enum logic [3:0] {
    REG_STAT  = 4'd0,
    REG_STATM = 4'd1,
    REG_ERR   = 4'd2,
    REG_ERRM  = 4'd3,
    REG_FCTL  = 4'd4,
    REG_ADDRH = 4'd5,
    REG_ADDRL = 4'd6,
    REG_SDATA = 4'd7,
    REG_KEY   = 4'd8
  } reg_e;

  function automatic logic [IDX_W-1:0] word_index(input logic [BANK_W-1:0] bank,
                                                  input logic [ROW_W-1:0] row);
    return {bank, row};
  endfunction

  function automatic logic [WBITS-1:0] bit_mask(input logic [BIT_W-1:0] b);
    return WBITS'(1) << b;
  endfunction
endpackage

// File: rtl/efuse_seq.sv
module efuse_seq
  import efuse_pkg::*;
#(
  parameter int PROG_CYCLES  = 6,
  parameter int SENSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_prog,
  input  logic             start_sense,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [BIT_W-1:0] bit_in,
  output logic             busy,
  output logic             prog_done,
  output logic             sense_done,
  output logic [IDX_W-1:0] op_idx,
  output logic [BIT_W-1:0] op_bit
);
  localparam int MAXC  = (PROG_CYCLES > SENSE_CYCLES) ? PROG_CYCLES : SENSE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             is_prog;
  logic             finishing;

  assign busy       = (cnt != '0);
  assign finishing  = (cnt == CNT_W'(1));
  assign prog_done  = finishing && is_prog;
  assign sense_done = finishing && !is_prog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      is_prog <= 1'b0;
      op_idx  <= '0;
      op_bit  <= '0;
    end else if (!busy && (start_prog || start_sense)) begin
      cnt     <= start_prog ? CNT_W'(PROG_CYCLES) : CNT_W'(SENSE_CYCLES);
      is_prog <= start_prog;
      op_idx  <= idx_in;
      op_bit  <= bit_in;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finishing) |=> (busy && $stable(op_idx) && $stable(op_bit) && $stable(is_prog)));

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done || sense_done) |=> !busy);
endmodule

// File: rtl/efuse_store.sv
module efuse_store
  import efuse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic [IDX_W-1:0] prog_idx,
  input  logic [BIT_W-1:0] prog_bit,
  input  logic             reload_en,
  input  logic [IDX_W-1:0] reload_idx,
  input  logic             ovr_en,
  input  logic [IDX_W-1:0] ovr_idx,
  input  logic [WBITS-1:0] ovr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WBITS-1:0] rd_word,
  input  logic [IDX_W-1:0] fuse_idx,
  output logic [WBITS-1:0] fuse_word
);
  logic [WBITS-1:0] fuse_mem [WORDS];
  logic [WBITS-1:0] ovr_mem  [WORDS];
  logic [WORDS-1:0] ovr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) fuse_mem[i] <= '0;
    end else if (prog_en) begin
      fuse_mem[prog_idx] <= fuse_mem[prog_idx] | bit_mask(prog_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= '0;
    end else begin
      if (reload_en) ovr_flag[reload_idx] <= 1'b0;
      if (ovr_en)    ovr_flag[ovr_idx]    <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ovr_en) ovr_mem[ovr_idx] <= ovr_data;
  end

  assign rd_word   = ovr_flag[rd_idx] ? ovr_mem[rd_idx] : fuse_mem[rd_idx];
  assign fuse_word = fuse_mem[fuse_idx];

  assert_fuse_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && fuse_idx == prog_idx) |=> fuse_word[$past(prog_bit)]);

  assert_prog_keeps_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_en && fuse_idx == prog_idx) |=> ((fuse_word & $past(fuse_word)) == $past(fuse_word)));
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
  import efuse_pkg::*;
#(
  parameter int PROG_CYCLES  = 6,
  parameter int SENSE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [BANKS-1:0]  prot_prog,
  input  logic [BANKS-1:0]  prot_read,
  input  logic [BANKS-1:0]  prot_ovr,
  output logic              irq
);
  logic [1:0]            stat_done, stat_mask;
  logic [7:0]            err, err_mask, err_set;
  logic [5:0]            addr_hi;
  logic [7:0]            addr_lo, sdata, key;

  logic                  is_arr, reg_hit;
  reg_e                  reg_sel;
  logic [BANK_W-1:0]     arr_bank, cur_bank;
  logic [ROW_W-1:0]      cur_row;
  logic [BIT_W-1:0]      cur_bit;
  logic [IDX_W-1:0]      cur_idx, op_idx;
  logic [BIT_W-1:0]      op_bit;
  logic                  busy, prog_done, sense_done;
  logic                  fctl_wr, req_prog, req_sense, key_ok;
  logic                  go_prog, go_sense, ovr_wr, ovr_refused, shadow_rd, rd_refused;
  logic [WBITS-1:0]      shadow_word, fuse_word;

  assign is_arr   = bus_addr[BUS_AW-1];
  assign reg_hit  = !is_arr && (bus_addr[BUS_AW-2:4] == '0);
  assign reg_sel  = reg_e'(bus_addr[3:0]);
  assign arr_bank = bus_addr[IDX_W-1:ROW_W];
  assign cur_bank = addr_hi[5:3];
  assign cur_row  = {addr_hi[2:0], addr_lo[7:3]};
  assign cur_bit  = addr_lo[2:0];
  assign cur_idx  = word_index(cur_bank, cur_row);

  assign fctl_wr   = bus_wr && reg_hit && (reg_sel == REG_FCTL);
  assign req_prog  = fctl_wr && bus_wdata[0] && !busy;
  assign req_sense = fctl_wr && bus_wdata[3] && !bus_wdata[0] && !busy;
  assign key_ok    = (key == UNLOCK_KEY);
  assign go_prog   = req_prog && key_ok && !prot_prog[cur_bank];
  assign go_sense  = req_sense && !prot_read[cur_bank];

  assign ovr_wr      = bus_wr && is_arr;
  assign ovr_refused = ovr_wr && prot_ovr[arr_bank];
  assign shadow_rd   = bus_rd && is_arr;
  assign rd_refused  = shadow_rd && prot_read[arr_bank];

  always_comb begin
    err_set          = '0;
    err_set[E_PROG]  = req_prog && !key_ok;
    err_set[E_WPROT] = req_prog && key_ok && prot_prog[cur_bank];
    err_set[E_OPROT] = ovr_refused;
    err_set[E_RPROT] = rd_refused;
    err_set[E_SENSE] = req_sense && prot_read[cur_bank];
  end

  efuse_seq #(.PROG_CYCLES(PROG_CYCLES), .SENSE_CYCLES(SENSE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_prog(go_prog), .start_sense(go_sense),
    .idx_in(cur_idx), .bit_in(cur_bit), .busy(busy), .prog_done(prog_done),
    .sense_done(sense_done), .op_idx(op_idx), .op_bit(op_bit));

  efuse_store u_store (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_done), .prog_idx(op_idx), .prog_bit(op_bit),
    .reload_en(sense_done), .reload_idx(op_idx), .ovr_en(ovr_wr && !ovr_refused),
    .ovr_idx(bus_addr[IDX_W-1:0]), .ovr_data(bus_wdata), .rd_idx(bus_addr[IDX_W-1:0]),
    .rd_word(shadow_word), .fuse_idx(op_idx), .fuse_word(fuse_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_done <= '0; stat_mask <= '0; err <= '0; err_mask <= '0;
      addr_hi <= '0; addr_lo <= '0; sdata <= '0; key <= '0;
    end else begin
      logic [1:0] sclr;
      logic [7:0] eclr;
      sclr = '0;
      eclr = '0;
      if (bus_wr && reg_hit) begin
        case (reg_sel)
          REG_STAT:  sclr = bus_wdata[1:0];
          REG_STATM: stat_mask <= bus_wdata[1:0];
          REG_ERR:   eclr = bus_wdata;
          REG_ERRM:  err_mask <= bus_wdata & ERR_VALID;
          REG_ADDRH: addr_hi <= bus_wdata[5:0];
          REG_ADDRL: addr_lo <= bus_wdata;
          REG_KEY:   key <= bus_wdata;
          default: ;
        endcase
      end
      stat_done <= (stat_done & ~sclr) | {prog_done, sense_done};
      err       <= ((err & ~eclr) | err_set) & ERR_VALID;
      if (sense_done) sdata <= fuse_word;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (is_arr) begin
      bus_rdata = prot_read[arr_bank] ? '0 : shadow_word;
    end else if (reg_hit) begin
      case (reg_sel)
        REG_STAT:  bus_rdata = {busy, 5'b0, stat_done};
        REG_STATM: bus_rdata = {6'b0, stat_mask};
        REG_ERR:   bus_rdata = err;
        REG_ERRM:  bus_rdata = err_mask;
        REG_ADDRH: bus_rdata = {2'b0, addr_hi};
        REG_ADDRL: bus_rdata = addr_lo;
        REG_SDATA: bus_rdata = sdata;
        REG_KEY:   bus_rdata = key;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assign irq = |(stat_done & stat_mask) || |(err & err_mask);

  assert_key_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fctl_wr && bus_wdata[0] && !busy && key != UNLOCK_KEY) |=> (!busy && err[E_PROG]));

  assert_ovr_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_wr && prot_ovr[arr_bank]) |=> err[E_OPROT]);

  assert_rd_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_rd && prot_read[arr_bank]) |-> (bus_rdata == 8'h00));

  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat_done != 2'b00) || (err != 8'h00)));
endmodule

// File: tb/efuse_ctrl_test.sv
module efuse_ctrl_test;
  localparam int PROG_CYC  = 6;
  localparam int SENSE_CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  prot_prog = '0, prot_read = '0, prot_ovr = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [7:0] m_fuse [2048];
  logic [7:0] m_ovr  [2048];
  bit         m_ovf  [2048];

  efuse_ctrl #(.PROG_CYCLES(PROG_CYC), .SENSE_CYCLES(SENSE_CYC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prot_prog(prot_prog),
    .prot_read(prot_read), .prot_ovr(prot_ovr), .irq(irq));

  always #2.5 clk = ~clk;

  function automatic logic [11:0] shadow_addr(input int bank, input int row);
    return 12'h800 | 12'((bank << 8) | row);
  endfunction

  function automatic logic [7:0] model_shadow(input int bank, input int row);
    int i = bank * 256 + row;
    return m_ovf[i] ? m_ovr[i] : m_fuse[i];
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_addr(input int bank, input int row, input int b);
    wr(12'h005, 8'((bank << 3) | (row >> 5)));
    wr(12'h006, 8'(((row & 31) << 3) | b));
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rd(12'h000, s);
      if (!s[7]) return;
    end
  endtask

  task automatic do_prog(input int bank, input int row, input int b);
    set_addr(bank, row, b);
    wr(12'h004, 8'h01);
    wait_idle();
    m_fuse[bank * 256 + row] |= 8'(1 << b);
  endtask

  task automatic do_sense(input int bank, input int row);
    set_addr(bank, row, 0);
    wr(12'h004, 8'h08);
    wait_idle();
    m_ovf[bank * 256 + row] = 0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) begin m_fuse[i] = 0; m_ovf[i] = 0; m_ovr[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, v); check("R1 status", v, 8'h00);
    rd(12'h002, v); check("R1 error", v, 8'h00);
    rd(12'h007, v); check("R1 sense data", v, 8'h00);
    rd(shadow_addr(7, 255), v); check("R1 shadow", v, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R5 program busy length, R6 program done, R2 addressing
    wr(12'h008, 8'hAA);
    set_addr(2, 8'hA5, 3);
    wr(12'h004, 8'h01);
    n = 0;
    for (int k = 0; k < 20; k++) begin rd(12'h000, v); if (!v[7]) break; n++; end
    check("R5 program busy cycles", 8'(n), 8'(PROG_CYC));
    check("R6 program done flag", v, 8'h02);
    m_fuse[2 * 256 + 8'hA5] |= 8'h08;
    rd(shadow_addr(2, 8'hA5), v); check("R2 R3 bit lands at bank/row/bit", v, 8'h08);
    rd(shadow_addr(2, 8'h25), v); check("R2 neighbour row untouched", v, 8'h00);

    // R5 sense busy length, R6 sense data
    wr(12'h000, 8'h03);
    wr(12'h004, 8'h08);
    n = 0;
    for (int k = 0; k < 20; k++) begin rd(12'h000, v); if (!v[7]) break; n++; end
    check("R5 sense busy cycles", 8'(n), 8'(SENSE_CYC));
    check("R6 sense done flag", v, 8'h01);
    rd(12'h007, v); check("R6 sense data", v, 8'h08);

    // R11 status clear
    wr(12'h000, 8'h00); rd(12'h000, v); check("R11 write 0 keeps", v, 8'h01);
    wr(12'h000, 8'h01); rd(12'h000, v); check("R11 write 1 clears", v, 8'h00);

    // R3 wrong key
    wr(12'h008, 8'h55);
    set_addr(2, 8'hA5, 0);
    wr(12'h004, 8'h01);
    rd(12'h000, v); check("R3 bad key no busy", v, 8'h00);
    rd(12'h002, v); check("R3 bad key error", v, 8'h80);
    rd(shadow_addr(2, 8'hA5), v); check("R3 bad key array unchanged", v, 8'h08);
    wr(12'h002, 8'h80); rd(12'h002, v); check("R11 error clear", v, 8'h00);

    // R4 write protect
    wr(12'h008, 8'hAA);
    prot_prog = 8'h10;
    set_addr(4, 3, 5);
    wr(12'h004, 8'h01);
    rd(12'h000, v); check("R4 no busy", v, 8'h00);
    rd(12'h002, v); check("R4 write-protect error", v, 8'h40);
    rd(shadow_addr(4, 3), v); check("R4 array unchanged", v, 8'h00);
    wr(12'h002, 8'hFE);
    prot_prog = 8'h00;

    // R5 start while busy ignored; R6 program wins when both bits written
    set_addr(1, 9, 6);
    wr(12'h004, 8'h09);
    wr(12'h004, 8'h08);
    wait_idle();
    m_fuse[1 * 256 + 9] |= 8'h40;
    rd(12'h000, v); check("R5 R6 only program done", v, 8'h02);
    rd(shadow_addr(1, 9), v); check("R6 program result", v, 8'h40);
    wr(12'h000, 8'h03);

    // R7 sense on read-protected bank
    prot_read = 8'h40;
    set_addr(6, 0, 0);
    wr(12'h004, 8'h08);
    rd(12'h000, v); check("R7 no busy", v, 8'h00);
    rd(12'h002, v); check("R7 sense error", v, 8'h04);
    wr(12'h002, 8'h04);

    // R9 read protect
    rd(shadow_addr(6, 0), v); check("R9 read returns 0", v, 8'h00);
    rd(12'h002, v); check("R9 read-protect error", v, 8'h10);
    wr(12'h002, 8'h10);
    prot_read = 8'h00;

    // R8 override and override protect
    wr(shadow_addr(1, 7), 8'h3C);
    m_ovf[256 + 7] = 1; m_ovr[256 + 7] = 8'h3C;
    rd(shadow_addr(1, 7), v); check("R8 override value", v, 8'h3C);
    prot_ovr = 8'h08;
    wr(shadow_addr(3, 7), 8'hFF);
    rd(shadow_addr(3, 7), v); check("R8 refused write keeps word", v, 8'h00);
    rd(12'h002, v); check("R8 override-protect error", v, 8'h20);
    wr(12'h002, 8'h20);
    prot_ovr = 8'h00;

    // R10 override hides programmed bit until sense reload
    do_prog(1, 7, 0);
    rd(shadow_addr(1, 7), v); check("R10 override still shown", v, 8'h3C);
    do_sense(1, 7);
    rd(12'h007, v); check("R10 sense data is fuse", v, 8'h01);
    rd(shadow_addr(1, 7), v); check("R10 shadow reloaded", v, 8'h01);
    wr(12'h000, 8'h03);

    // R12 interrupt masking
    wr(12'h008, 8'h00);
    wr(12'h004, 8'h01);
    check("R12 unmasked error no irq", {7'b0, irq}, 8'h00);
    wr(12'h003, 8'h80);
    check("R12 masked error irq", {7'b0, irq}, 8'h01);
    wr(12'h002, 8'h80);
    check("R12 cleared irq", {7'b0, irq}, 8'h00);
    wr(12'h001, 8'h02);
    wr(12'h008, 8'hAA);
    do_prog(0, 1, 1);
    check("R12 program done irq", {7'b0, irq}, 8'h01);
    wr(12'h000, 8'h02);
    check("R12 done cleared irq", {7'b0, irq}, 8'h00);
    wr(12'h001, 8'h00); wr(12'h003, 8'h00);

    // Random mix: programs, overrides, senses checked against model (R2 R3 R8 R10)
    for (int it = 0; it < 60; it++) begin
      int bank = int'($urandom_range(7, 0));
      int row  = int'($urandom_range(15, 0)) * 17;
      int sel  = int'($urandom_range(3, 0));
      if (sel == 0) begin
        logic [7:0] d = 8'($urandom);
        wr(shadow_addr(bank, row), d);
        m_ovf[bank * 256 + row] = 1; m_ovr[bank * 256 + row] = d;
      end else if (sel == 1) begin
        do_sense(bank, row);
        rd(12'h007, v); check("R6 R10 random sense data", v, m_fuse[bank * 256 + row]);
      end else begin
        do_prog(bank, row, int'($urandom_range(7, 0)));
      end
      rd(shadow_addr(bank, row), v);
      check("R3 R8 random shadow", v, model_shadow(bank, row));
    end
    rd(12'h002, v); check("R3 random no errors", v, 8'h00);

    finish_up();
  end
endmodule